// File: doc/BRIEF.md
# Serial Stereo Converter Stream Transmitter

This block feeds a dual-channel serial digital-to-analog converter. It takes a left and right 16-bit two's complement sample pair through a ready/valid handshake. It sends both words at the same time on two data lines that share one bit clock. After the last bit of each word it drives a low pulse on the two latch lines, and the falling edge of that pulse loads the word into the converter. The word rate is 2, 4, 8 or 16 times a 44.1 kHz base rate, chosen by a two-bit select. The bit clock half-period, counted in system cycles, is set at run time. It is clamped so that the clock never runs faster than 13.5 MHz and the whole word still fits in the selected word period.

Every interval the converter needs is turned into a whole number of system cycles at elaboration. These intervals are clock high and low time, data setup and hold, latch setup and latch pulse width. A one-entry pair buffer sits in front of the serialiser. If no new pair has been accepted when a word starts, the previous pair is sent again.

Top module: `stereo_dac_tx`

## Requirements
- R1: Each word carries 16 bits, most significant bit first. Both data lines shift together on the shared bit clock, and the receiver takes each bit on a rising edge. There are exactly 16 rising edges of the bit clock per word.
- R2: A data line changes only at a falling edge of the bit clock or when the word ends, never while the clock is high. Each bit is stable for at least 8 system cycles (30 ns at 250 MHz) before its rising edge.
- R3: The bit clock high and low times both equal the effective half-period H. H is the half_cfg_i value clamped to the range from 10 up to a per-rate ceiling. The ceilings are 87, 43, 21 and 10 for rate_sel_i values 0, 1, 2 and 3 at the defaults.
- R4: Both latch lines idle high and fall together once per word. Each falls at least 10 system cycles (40 ns) after the last rising edge of the bit clock and stays low for exactly 10 system cycles.
- R5: rate_sel_i selects 2x (0), 4x (1), 8x (2) or 16x (3) of 44.1 kHz. Successive latch falling edges are 2834, 1417, 708 or 354 system cycles apart. A change to rate_sel_i or half_cfg_i takes effect at the next word start.
- R6: in_ready_o is high exactly when the one-entry pair buffer is empty. After a transfer it drops until the next word start takes the pair.
- R7: If no pair is waiting when a word starts, the previous pair is sent again. Zero is sent before any pair has been accepted.
- R8: Between words, once all bits have been sent, the bit clock and both data lines are low. In particular they are low during the whole latch pulse.
- R9: While reset is held, in_ready_o is high, both latch lines are high, and the bit clock and both data lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_sel_i | input | 2 | Word rate select: 0=2x, 1=4x, 2=8x, 3=16x of 44.1 kHz |
| half_cfg_i | input | DIV_W (8) | Requested bit clock half-period in system cycles |
| in_valid_i | input | 1 | A sample pair is offered |
| in_ready_o | output | 1 | The pair buffer can take a pair |
| in_left_i | input | 16 | Left sample, two's complement |
| in_right_i | input | 16 | Right sample, two's complement |
| bclk_o | output | 1 | Shared serial bit clock |
| sd_left_o | output | 1 | Left serial data |
| sd_right_o | output | 1 | Right serial data |
| lat_left_n_o | output | 1 | Left latch, active-low load strobe |
| lat_right_n_o | output | 1 | Right latch, active-low load strobe |

## Verification
The bench decodes both data lines on every rising edge and compares each decoded word against a scoreboard. The scoreboard is filled at handshake time, so a buffer that dropped, doubled or reordered pairs gets out of step at once. A design that cleared the held pair at word start would send zeros on the repeated words. The bench drives half-period requests below the floor, above the per-rate ceiling and exactly at a ceiling. A clamp error shows up as a wrong high or low width, or as a word period that misses 2834, 1417, 708 or 354 cycles. The bench also measures the gap from the last rising edge to the latch falling edge and the latch low width. It watches for data moving while the clock is high, which would happen if bits were shifted on the wrong clock phase.

// File: rtl/stereo_dac_pkg.sv
package stereo_dac_pkg;

  typedef enum logic [1:0] {
    SQ_GAP   = 2'd0,
    SQ_BITS  = 2'd1,
    SQ_TAIL  = 2'd2,
    SQ_LATCH = 2'd3
  } sq_state_e;

  localparam int NUM_RATES = 4;

  // smallest whole number of system cycles covering ns nanoseconds
  function automatic int ns_to_cycles(input longint ns, input longint hz);
    return int'((ns * hz + longint'(999_999_999)) / longint'(1_000_000_000));
  endfunction

  // system cycles per word for rate index idx (multiple 2 << idx)
  function automatic int word_cycles(input longint hz, input longint base, input int idx);
    return int'(hz / (base * (longint'(2) << idx)));
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdt_word_timer.sv
module sdt_word_timer
  import stereo_dac_pkg::*;
#(
  parameter longint SYS_HZ  = 250_000_000,
  parameter longint BASE_HZ = 44_100,
  parameter int     TMR_W   = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_sel_i,
  output logic       word_start_o
);

  logic [TMR_W-1:0] lim_c [NUM_RATES];
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic [1:0]       rate_q, rate_d;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_lim
    localparam int WC = word_cycles(SYS_HZ, BASE_HZ, g);
    assign lim_c[g] = TMR_W'(WC - 1);
  end

  always_comb begin
    word_start_o = (cnt_q == '0);
    rate_d       = word_start_o ? rate_sel_i : rate_q;
    cnt_d        = (cnt_q >= lim_c[rate_q]) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rate_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      rate_q <= rate_d;
    end
  end

endmodule

// File: rtl/sdt_pair_buf.sv
module sdt_pair_buf #(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                word_start_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [W-1:0]        in_left_i,
  input  logic [W-1:0]        in_right_i,
  output logic [1:0][W-1:0]   load_o
);

  logic             full_q, full_d;
  logic [1:0][W-1:0] pend_q, pend_d;
  logic [1:0][W-1:0] cur_q, cur_d;
  logic             accept;
  logic             pend_en, cur_en;

  always_comb begin
    in_ready_o = ~full_q;
    accept     = in_valid_i & ~full_q;
    load_o     = full_q ? pend_q : cur_q;
    full_d     = accept | (full_q & ~word_start_i);
    pend_en    = accept;
    cur_en     = word_start_i;
    pend_d[0]  = in_left_i;
    pend_d[1]  = in_right_i;
    cur_d      = load_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      pend_q <= '0;
      cur_q  <= '0;
    end else begin
      full_q <= full_d;
      if (pend_en) pend_q <= pend_d;
      if (cur_en)  cur_q  <= cur_d;
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o); // R6

endmodule

// File: rtl/sdt_shifter.sv
module sdt_shifter #(
  parameter int W   = 16,
  parameter int NCH = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  shift_i,
  input  logic                  en_i,
  input  logic [NCH-1:0][W-1:0] par_i,
  output logic [NCH-1:0]        ser_o
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [W-1:0] sh_q, sh_d;
    logic         sh_en;

    always_comb begin
      sh_en = load_i | shift_i;
      sh_d  = load_i ? par_i[ch] : {sh_q[W-2:0], 1'b0};
      ser_o[ch] = en_i & sh_q[W-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= '0;
      end else if (sh_en) begin
        sh_q <= sh_d;
      end
    end
  end

endmodule

// File: rtl/sdt_frame_seq.sv
module sdt_frame_seq
  import stereo_dac_pkg::*;
#(
  parameter longint SYS_HZ   = 250_000_000,
  parameter longint BASE_HZ  = 44_100,
  parameter int     W        = 16,
  parameter int     DIV_W    = 8,
  parameter int     LAT_CYC  = 10,
  parameter int     MIN_HALF = 10,
  parameter int     NCH      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_start_i,
  input  logic [1:0]       rate_sel_i,
  input  logic [DIV_W-1:0] half_cfg_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             data_en_o,
  output logic             idle_o,
  output logic             bclk_o,
  output logic [NCH-1:0]   lat_n_o
);

  localparam int CNT_W = max_int(DIV_W, $clog2(LAT_CYC + 1));
  localparam int BIT_W = $clog2(W);

  logic [CNT_W-1:0] hmax_c [NUM_RATES];
  logic [CNT_W-1:0] cfg_ext, cfg_cap, eff_half;

  sq_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half_q, half_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             phase_q, phase_d;
  logic             half_end, lat_end, last_bit;

  // per-rate ceiling: 2*W half-periods plus both latch intervals and margin fit the word
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_hmax
    localparam int HM = (word_cycles(SYS_HZ, BASE_HZ, g) - 2 * LAT_CYC - 2) / (2 * W);
    assign hmax_c[g] = CNT_W'(HM);
  end

  always_comb begin
    cfg_ext  = CNT_W'(half_cfg_i);
    cfg_cap  = (cfg_ext > hmax_c[rate_sel_i]) ? hmax_c[rate_sel_i] : cfg_ext;
    eff_half = (cfg_cap < CNT_W'(MIN_HALF)) ? CNT_W'(MIN_HALF) : cfg_cap;
  end

  always_comb begin
    half_end = (cnt_q == half_q - 1'b1);
    lat_end  = (cnt_q == CNT_W'(LAT_CYC - 1));
    last_bit = (bit_q == BIT_W'(W - 1));
    st_d     = st_q;
    cnt_d    = cnt_q;
    half_d   = half_q;
    bit_d    = bit_q;
    phase_d  = phase_q;
    shift_o  = 1'b0;
    load_o   = word_start_i;
    if (word_start_i) begin
      st_d    = SQ_BITS;
      cnt_d   = '0;
      half_d  = eff_half;
      bit_d   = '0;
      phase_d = 1'b0;
    end else begin
      unique case (st_q)
        SQ_BITS: begin
          if (half_end) begin
            cnt_d = '0;
            if (!phase_q) begin
              phase_d = 1'b1;
            end else if (last_bit) begin
              phase_d = 1'b0;
              st_d    = SQ_TAIL;
            end else begin
              phase_d = 1'b0;
              bit_d   = bit_q + 1'b1;
              shift_o = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SQ_TAIL: begin
          if (lat_end) begin
            cnt_d = '0;
            st_d  = SQ_LATCH;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SQ_LATCH: begin
          if (lat_end) begin
            cnt_d = '0;
            st_d  = SQ_GAP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_GAP;
      cnt_q   <= '0;
      half_q  <= CNT_W'(MIN_HALF);
      bit_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      bit_q   <= bit_d;
      phase_q <= phase_d;
    end
  end

  always_comb begin
    bclk_o    = phase_q;
    data_en_o = (st_q == SQ_BITS);
    idle_o    = (st_q == SQ_GAP);
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lat
    assign lat_n_o[ch] = (st_q != SQ_LATCH);
  end

  AST_HALF_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_o) |-> (half_q >= CNT_W'(MIN_HALF))); // R3

endmodule

// File: rtl/stereo_dac_tx.sv
module stereo_dac_tx
  import stereo_dac_pkg::*;
#(
  parameter longint SYS_HZ       = 250_000_000,
  parameter longint BASE_HZ      = 44_100,
  parameter longint BCLK_MAX_HZ  = 13_500_000,
  parameter int     SAMPLE_W     = 16,
  parameter int     DIV_W        = 8,
  parameter int     CLK_PHASE_NS = 30,
  parameter int     SETUP_NS     = 30,
  parameter int     LATCH_NS     = 40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          rate_sel_i,
  input  logic [DIV_W-1:0]    half_cfg_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] in_left_i,
  input  logic [SAMPLE_W-1:0] in_right_i,
  output logic                bclk_o,
  output logic                sd_left_o,
  output logic                sd_right_o,
  output logic                lat_left_n_o,
  output logic                lat_right_n_o
);

  localparam int NCH      = 2;
  localparam int RATE_MIN = int'((SYS_HZ + 2 * BCLK_MAX_HZ - 1) / (2 * BCLK_MAX_HZ));
  localparam int MIN_HALF = max_int(RATE_MIN,
                              max_int(ns_to_cycles(CLK_PHASE_NS, SYS_HZ),
                                      ns_to_cycles(SETUP_NS, SYS_HZ)));
  localparam int LAT_CYC  = ns_to_cycles(LATCH_NS, SYS_HZ);
  localparam int TMR_W    = $clog2(word_cycles(SYS_HZ, BASE_HZ, 0) + 1);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic                       word_start;
  logic [NCH-1:0][SAMPLE_W-1:0] load_pair;
  logic                       load, shift, data_en, seq_idle;
  logic [NCH-1:0]             ser, lat_n;

  sdt_word_timer #(
    .SYS_HZ (SYS_HZ),
    .BASE_HZ(BASE_HZ),
    .TMR_W  (TMR_W)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .rate_sel_i  (rate_sel_i),
    .word_start_o(word_start)
  );

  sdt_pair_buf #(.W(SAMPLE_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .word_start_i(word_start),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_left_i   (in_left_i),
    .in_right_i  (in_right_i),
    .load_o      (load_pair)
  );

  sdt_frame_seq #(
    .SYS_HZ  (SYS_HZ),
    .BASE_HZ (BASE_HZ),
    .W       (SAMPLE_W),
    .DIV_W   (DIV_W),
    .LAT_CYC (LAT_CYC),
    .MIN_HALF(MIN_HALF),
    .NCH     (NCH)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .word_start_i(word_start),
    .rate_sel_i  (rate_sel_i),
    .half_cfg_i  (half_cfg_i),
    .load_o      (load),
    .shift_o     (shift),
    .data_en_o   (data_en),
    .idle_o      (seq_idle),
    .bclk_o      (bclk_o),
    .lat_n_o     (lat_n)
  );

  sdt_shifter #(.W(SAMPLE_W), .NCH(NCH)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .load_i (load),
    .shift_i(shift),
    .en_i   (data_en),
    .par_i  (load_pair),
    .ser_o  (ser)
  );

  always_comb begin
    sd_left_o     = ser[0];
    sd_right_o    = ser[1];
    lat_left_n_o  = lat_n[0];
    lat_right_n_o = lat_n[1];
  end

  AST_DATA_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (bclk_o && $past(bclk_o)) |-> ($stable(sd_left_o) && $stable(sd_right_o))); // R2

  AST_IDLE_IN_LATCH: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !lat_left_n_o |-> (!bclk_o && !sd_left_o && !sd_right_o)); // R8

  AST_WORD_FITS: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    word_start |-> seq_idle); // R5

endmodule

// File: tb/stereo_dac_tx_tb.sv
module stereo_dac_tx_tb;

  localparam int MIN_H    = 10;
  localparam int LAT      = 10;
  localparam int SETUP_MIN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate_sel = 2'd3;
  logic [7:0]  half_cfg = 8'd10;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_left = '0, in_right = '0;
  logic        bclk, sd_l, sd_r, lat_l, lat_r;

  always #2 clk = ~clk;

  stereo_dac_tx u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rate_sel_i   (rate_sel),
    .half_cfg_i   (half_cfg),
    .in_valid_i   (in_valid),
    .in_ready_o   (in_ready),
    .in_left_i    (in_left),
    .in_right_i   (in_right),
    .bclk_o       (bclk),
    .sd_left_o    (sd_l),
    .sd_right_o   (sd_r),
    .lat_left_n_o (lat_l),
    .lat_right_n_o(lat_r)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int word_len(input int r);
    case (r)
      0: return 2834;
      1: return 1417;
      2: return 708;
      default: return 354;
    endcase
  endfunction

  function automatic int half_ceiling(input int r);
    case (r)
      0: return 87;
      1: return 43;
      2: return 21;
      default: return 10;
    endcase
  endfunction

  // scoreboard
  logic [31:0] exp_q [$];
  logic [31:0] last_exp = '0;
  int  exp_h  = 10;
  int  exp_wc = 354;
  int  skip   = 1;
  event lat_fall_ev;

  // monitor state
  bit   p_bclk = 0, p_l = 0, p_r = 0, p_lat = 1;
  int   tc = 0, last_fall = 0;
  bit   have_prev = 0;
  int   stab = 0, setup_min = 1000, hold_bad = 0, lat_mis = 0;
  int   hi_len = 0, lo_len = 0, hi_min = 1000, hi_max = 0, lo_min = 1000, lo_max = 0;
  int   rise_cnt = 0, since_rise = 0, low_len = 0;
  logic [15:0] sl = '0, sr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      tc++;
      since_rise++;
      if ((sd_l != p_l) || (sd_r != p_r)) begin
        stab = 0;
        if (bclk && p_bclk) hold_bad++;
      end else begin
        stab++;
      end
      if (lat_l != lat_r) lat_mis++;
      if (bclk) hi_len = p_bclk ? hi_len + 1 : 1;
      else      lo_len = p_bclk ? 1 : lo_len + 1;
      if (bclk && !p_bclk) begin
        if (rise_cnt > 0) begin
          if (lo_len < lo_min) lo_min = lo_len;
          if (lo_len > lo_max) lo_max = lo_len;
        end
        if (stab < setup_min) setup_min = stab;
        sl = {sl[14:0], sd_l};
        sr = {sr[14:0], sd_r};
        rise_cnt++;
        since_rise = 0;
      end
      if (!bclk && p_bclk) begin
        if (p_bclk && hi_len < hi_min) hi_min = hi_len;
        if (hi_len > hi_max) hi_max = hi_len;
      end
      if (!lat_l && !p_lat) low_len++;
      if (lat_l && !p_lat)
        check(low_len == LAT, "R4 latch low width", low_len, LAT);
      if (!lat_l && p_lat) begin
        low_len = 1;
        if (exp_q.size() > 0) last_exp = exp_q.pop_front();
        check(sl == last_exp[31:16], "R1/R7 left word", sl, last_exp[31:16]);
        check(sr == last_exp[15:0], "R1/R7 right word", sr, last_exp[15:0]);
        check(rise_cnt == 16, "R1 rising edges per word", rise_cnt, 16);
        check(setup_min >= SETUP_MIN && hold_bad == 0, "R2 setup/stable while high",
              setup_min, SETUP_MIN);
        check(hi_min == exp_h && hi_max == exp_h, "R3 high width", hi_max, exp_h);
        check(lo_min == exp_h && lo_max == exp_h, "R3 low width", lo_max, exp_h);
        check(since_rise >= LAT && !lat_r, "R4 latch setup and both lines", since_rise, LAT);
        check(!bclk && !sd_l && !sd_r, "R8 idle low at latch", {bclk, sd_l, sd_r}, 0);
        if (have_prev && skip == 0)
          check(tc - last_fall == exp_wc, "R5 word period", tc - last_fall, exp_wc);
        if (skip > 0) skip--;
        have_prev = 1;
        last_fall = tc;
        rise_cnt = 0; setup_min = 1000; hold_bad = 0;
        hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0;
        sl = '0; sr = '0;
        -> lat_fall_ev;
      end
      p_bclk = bclk; p_l = sd_l; p_r = sd_r; p_lat = lat_l;
    end
  end

  task automatic wait_fall();
    @(lat_fall_ev);
  endtask

  task automatic push(input logic [15:0] l, input logic [15:0] r);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_left  = l;
    in_right = r;
    @(posedge clk);
    exp_q.push_back({l, r});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_cfg(input int r, input int h);
    int v;
    rate_sel = r[1:0];
    half_cfg = h[7:0];
    v = (h > half_ceiling(r)) ? half_ceiling(r) : h;
    exp_h  = (v < MIN_H) ? MIN_H : v;
    exp_wc = word_len(r);
    skip   = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    check(in_ready == 1'b1, "R9 ready in reset", in_ready, 1);
    check(lat_l && lat_r, "R9 latches high in reset", {lat_l, lat_r}, 3);
    check(!bclk && !sd_l && !sd_r, "R9 clock/data low in reset", {bclk, sd_l, sd_r}, 0);
    rst_n = 1'b1;

    wait_fall();                                // R7 zero before any pair
    push(16'h8001, 16'h7FFE);
    wait_fall();                                // R1 extremes
    push(16'hA5C3, 16'h0F0F);
    wait_fall();
    wait_fall();                                // R7 repeat
    wait_fall();

    push(16'h1234, 16'hFEDC);
    check(in_ready == 1'b0, "R6 ready low while held", in_ready, 0);
    push(16'h00FF, 16'hFF00);                   // waits for word start
    wait_fall();
    wait_fall();

    set_cfg(3, 3);                              // R3 floor
    push(16'h5555, 16'hAAAA);
    wait_fall();
    wait_fall();

    set_cfg(0, 200);                            // R3 ceiling, R5 2x
    push(16'h0001, 16'hFFFF);
    repeat (3) wait_fall();

    set_cfg(0, 12);
    push(16'h7FFF, 16'h8000);
    repeat (3) wait_fall();

    set_cfg(1, 20);                             // R5 4x
    repeat (3) wait_fall();

    set_cfg(2, 21);                             // R3 exactly at 8x ceiling
    push(16'hC001, 16'h3FFE);
    repeat (3) wait_fall();

    set_cfg(3, 10);                             // R5 16x
    repeat (3) wait_fall();

    check(lat_mis == 0, "R4 latch lines together", lat_mis, 0);
    check(exp_q.size() == 0, "R6 all pairs sent", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule